// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four asynchronous interrupt pins and presents one interrupt request per pin to the processor. Each line can be set independently to respond to a high level, a low level, a rising edge, a falling edge, or any transition. Every pin passes through a two-flop synchronizer first. Edge events are then held in a per-line latch until software acknowledges them.

All control sits in one 32-bit register, which a plain address, write-enable and data port reaches. For each line the register holds an enable (mask) bit, a level-select bit, a polarity bit, an any-edge bit, and a write-one acknowledge bit. Level lines have no latch, so they follow the synchronized pin. Edge lines keep their event latched while masked, so no event is lost when a line is disabled for a while.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the register reads 0x0000_F000: every line is level-select 1 and polarity 0 (active-low level), any-edge 0, mask 0. All interrupt outputs are low.
- R2: Only address 0 selects the register. Its bit layout is: [3:0] acknowledge, [7:4] polarity, [11:8] any-edge, [15:12] level-select, [19:16] mask, with line n at bit n of each field. The acknowledge bits and bits [31:20] always read 0. Any other address reads 0, and writes to it change nothing.
- R3: With level-select 1 and polarity 1, an unmasked line's output equals the pin value seen through two clock edges of synchronization.
- R4: With level-select 1 and polarity 0, an unmasked line's output equals the inverted, synchronized pin value.
- R5: With level-select 0, any-edge 0 and polarity 1, a rising pin edge sets the line's latch. The output rises at the third clock edge after the pin changes. Falling edges are ignored.
- R6: With level-select 0, any-edge 0 and polarity 0, only falling edges set the latch, with the same latency as R5.
- R7: With level-select 0 and any-edge 1, both rising and falling edges set the latch, whatever the polarity bit.
- R8: An output is high only while its mask bit is 1. A masked edge line still latches events, and its output goes high as soon as the mask is set again, unless it was acknowledged in between.
- R9: Writing 1 to a line's acknowledge bit clears its latch. If an edge is detected in the same cycle as that write, the edge wins and the latch stays set.
- R10: A line in level mode holds no latched event, and writing its acknowledge bit has no effect on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous interrupt pins, one per line |
| reg_addr | input | 4 | Register address; 0 selects the control register |
| reg_we | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 4 | Interrupt requests, one per line |

## Verification
The bench aims an acknowledge write at the exact cycle in which a new edge is detected. A design that let the acknowledge win would drop that event and leave the output low. It acknowledges a latch while the line is masked and then unmasks it; a design that cleared the latch on masking, or did not latch while masked, would show the wrong output after unmasking. It writes acknowledge bits to level lines, where a design with a hidden latch would make the output stick or drop. Random pin activity and register writes, including writes to a wrong address, are then checked every cycle against a model of each sense mode, which catches a swapped polarity, a swapped field, or a missing synchronizer stage.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LINES-1:0]  irq_o
);
  localparam int F_ACK  = 0;
  localparam int F_POL  = LINES;
  localparam int F_ANY  = 2 * LINES;
  localparam int F_LVL  = 3 * LINES;
  localparam int F_MASK = 4 * LINES;
  localparam int USED   = 5 * LINES;

  logic [LINES-1:0] mask_q, lvl_q, any_q, pol_q;
  logic [LINES-1:0] s1_q, s2_q, prev_q, pend_q;

  logic             sel, cfg_wr;
  logic [LINES-1:0] ack, rise, fall, hit;
  logic             unused_wdata_hi;

  assign sel    = (reg_addr == '0);
  assign cfg_wr = reg_we && sel;
  assign ack    = cfg_wr ? reg_wdata[F_ACK +: LINES] : '0;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:USED];

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
  assign hit  = ~lvl_q & ((any_q & (rise | fall)) |
                          (~any_q & pol_q & rise) |
                          (~any_q & ~pol_q & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
      lvl_q  <= '1;
      any_q  <= '0;
      pol_q  <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_q <= ~lvl_q & ((pend_q & ~ack) | hit);
      if (cfg_wr) begin
        mask_q <= reg_wdata[F_MASK +: LINES];
        lvl_q  <= reg_wdata[F_LVL  +: LINES];
        any_q  <= reg_wdata[F_ANY  +: LINES];
        pol_q  <= reg_wdata[F_POL  +: LINES];
      end
    end
  end

  assign reg_rdata = sel ? {{(DATA_W-USED){1'b0}}, mask_q, lvl_q, any_q, pol_q, {LINES{1'b0}}}
                         : '0;

  assign irq_o = mask_q & ((lvl_q & ~(pol_q ^ s2_q)) | (~lvl_q & pend_q));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mask_q == $past(reg_wdata[F_MASK +: LINES])) &&
               (lvl_q  == $past(reg_wdata[F_LVL  +: LINES])));

  // R2
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel) |=> $stable(mask_q) && $stable(lvl_q) && $stable(any_q) && $stable(pol_q));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> pend_q[g]);

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !hit[g]) |=> !pend_q[g]);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !lvl_q[g] && !ack[g]) |=> pend_q[g]);

    // R10
    no_level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q[g] |=> !pend_q[g]);
  end
endmodule

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_i = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // reference state built from the requirements
  logic [3:0] m_mask, m_lvl, m_any, m_pol, m_s1, m_s2, m_prev, m_pend;

  function automatic bit edge_event(bit lvl, bit any, bit pol, bit cur, bit prv);
    if (lvl) return 1'b0;
    if (cur == prv) return 1'b0;
    if (any) return 1'b1;
    return pol ? cur : prv;
  endfunction

  function automatic bit exp_line(int i);
    if (!m_mask[i]) return 1'b0;
    if (m_lvl[i]) return m_pol[i] ? m_s2[i] : ~m_s2[i];
    return m_pend[i];
  endfunction

  function automatic string line_tag(int i);
    if (!m_mask[i]) return "R8";
    if (m_lvl[i]) return m_pol[i] ? "R3" : "R4";
    if (m_any[i]) return "R7";
    return m_pol[i] ? "R5" : "R6";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0; m_lvl <= '1; m_any <= '0; m_pol <= '0;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
    end else begin
      logic [3:0] ackv, nxt;
      ackv = (reg_we && reg_addr == 0) ? reg_wdata[3:0] : 4'h0;
      for (int i = 0; i < 4; i++) begin
        if (m_lvl[i]) nxt[i] = 1'b0;
        else nxt[i] = edge_event(m_lvl[i], m_any[i], m_pol[i], m_s2[i], m_prev[i]) |
                      (m_pend[i] & ~ackv[i]);
      end
      m_pend <= nxt;
      m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (reg_we && reg_addr == 0) begin
        m_pol  <= reg_wdata[7:4];
        m_any  <= reg_wdata[11:8];
        m_lvl  <= reg_wdata[15:12];
        m_mask <= reg_wdata[19:16];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_model();
    logic [31:0] exp_rd;
    for (int i = 0; i < 4; i++) chk(line_tag(i), 32'(irq_o[i]), 32'(exp_line(i)));
    exp_rd = (reg_addr == 0) ? {12'h0, m_mask, m_lvl, m_any, m_pol, 4'h0} : 32'h0;
    chk("R2", reg_rdata, exp_rd);
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_model();
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", reg_rdata, 32'h0000_F000);
    chk("R1", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    step(2);

    // line0 level-high, line1 level-low, line2 rising, line3 falling, all unmasked
    wr(4'h0, 32'h000F_3050);
    chk("R2", reg_rdata, 32'h000F_3050);
    pin_i = 4'b0011;
    step(2);
    chk("R3", 32'(irq_o[0]), 32'h1);
    chk("R4", 32'(irq_o[1]), 32'h0);
    pin_i = 4'b1100;                      // line2 rises, line3 rises
    step(3);
    chk("R5", 32'(irq_o[2]), 32'h1);
    chk("R6", 32'(irq_o[3]), 32'h0);
    pin_i = 4'b0000;                      // line3 falls
    step(3);
    chk("R6", 32'(irq_o[3]), 32'h1);
    wr(4'h0, 32'h000F_305F);              // acknowledge all
    chk("R9", 32'(irq_o[3:2]), 32'h0);

    // any-edge on line2, polarity 0
    wr(4'h0, 32'h000F_3410);
    pin_i[2] = 1'b1; step(3);
    chk("R7", 32'(irq_o[2]), 32'h1);
    wr(4'h0, 32'h000F_3414);
    pin_i[2] = 1'b0; step(3);
    chk("R7", 32'(irq_o[2]), 32'h1);
    wr(4'h0, 32'h000F_3414);

    // masked line still latches, unmask reveals it
    wr(4'h0, 32'h000B_3410);
    pin_i[2] = 1'b1; step(4);
    chk("R8", 32'(irq_o[2]), 32'h0);
    chk("R8", reg_rdata, 32'h000B_3410);
    wr(4'h0, 32'h000F_3410);
    chk("R8", 32'(irq_o[2]), 32'h1);
    // acknowledge while masked, then unmask: stays low
    wr(4'h0, 32'h000B_3414);
    wr(4'h0, 32'h000F_3410);
    chk("R8", 32'(irq_o[2]), 32'h0);

    // edge detected in the acknowledge cycle wins
    pin_i[2] = 1'b0; step(2);
    wr(4'h0, 32'h000F_3414);
    chk("R9", 32'(irq_o[2]), 32'h1);
    wr(4'h0, 32'h000F_3414);
    chk("R9", 32'(irq_o[2]), 32'h0);

    // acknowledge on a level line does nothing
    pin_i[0] = 1'b1; step(2);
    wr(4'h0, 32'h000F_3411);
    chk("R10", 32'(irq_o[0]), 32'h1);
    step(2);
    chk("R10", 32'(irq_o[0]), 32'h1);

    // wrong address: ignored, reads 0
    wr(4'h3, 32'h0000_0000);
    reg_addr = 4'h3; step();
    chk("R2", reg_rdata, 32'h0);
    reg_addr = 4'h0; step();
    chk("R2", reg_rdata, 32'h000F_3410);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 3) == 0) pin_i = 4'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        reg_we = 1'b1;
        reg_addr = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
        reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
        reg_addr = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      end
      step();
    end
    reg_we = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule